// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture

This block timestamps transitions on two external pins against a shared 16-bit free-running counter. The counter advances on a tick from a prescaler, and a 2-bit clock-select input sets the divide ratio. Each channel synchronises its pin and looks for the transition chosen by its polarity bit. On a match it copies the counter into a read-only 16-bit capture register and raises that channel's capture flag. Software reads each capture register as two bytes. When the high byte is read, the channel locks until the low byte is accessed, so the two bytes always come from the same capture. A capture flag clears only by a read of the status byte while the flag is set, followed by an access to that channel's low byte. An overflow flag marks each wrap of the counter, so software can measure intervals longer than the counter range.

The register port is a plain single-cycle strobe interface: address, read strobe and write strobe, with read data driven combinationally from the address. It has no back-pressure. Every access completes in the cycle its strobe is high, and any side effect of an access takes effect at the next clock edge. Writes carry no data; their only effect is to count as a low-byte access. One combined interrupt request goes high when any capture flag is set, the capture interrupt enable is high and the global mask is low. While the waveform-mode input is high, only channel 1 may capture.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset the counter, both capture registers, the status byte, every flag and `irq` are all zero.
- R2: With `clk_sel` = s, the counter advances by one every 2^s clocks. After reset release it first advances at clock 2^s. It is read at address 5 (high byte) and address 6 (low byte).
- R3: If a pin change is settled before clock edge k, the channel's flag is set at edge k+2, and its capture register then holds the counter value present after edge k+1. The flag is still clear after edge k+1.
- R4: `edge_sel[i]` = 1 selects rising transitions for channel i and 0 selects falling transitions. A transition of the other polarity neither captures nor sets the flag.
- R5: Status byte at address 0: bit 0 is the channel 0 flag, bit 1 is the channel 1 flag, bit 2 is the overflow flag, and all other bits read 0. The channel 0 capture register is at addresses 1 (high) and 2 (low). The channel 1 capture register is at addresses 3 (high) and 4 (low).
- R6: A status read while a capture flag is set arms that flag. A following read or write of the channel's low byte then clears it. A low-byte access that has not been armed leaves the flag set.
- R7: A new capture on a channel after its status read and before its low-byte access cancels the arming, and the flag stays set.
- R8: A read of a channel's high byte locks that channel until its low byte is accessed. While locked, active transitions neither change the capture register nor set the flag.
- R9: `irq` is high exactly when a capture flag is set, `cap_irq_en` is high and `irq_mask` is low. A pending flag raises `irq` as soon as both conditions hold.
- R10: While `wave_mode` is high, channel 0 ignores its pin. Channel 1 still captures.
- R11: The overflow flag sets when the counter wraps from FFFFh to 0. It clears by a status read while it is set, followed by a read or write of address 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Prescaler select; ratio 2^clk_sel |
| edge_sel | input | 2 | Per-channel polarity, 1 = rising |
| cap_irq_en | input | 1 | Capture interrupt enable, shared by both channels |
| irq_mask | input | 1 | Global interrupt mask, 1 = masked |
| wave_mode | input | 1 | Waveform mode active; suppresses channel 0 |
| cap_pin | input | 2 | Capture pins, asynchronous |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe (no data) |
| bus_addr | input | 3 | Register address |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Combined capture interrupt request |

## Verification
A wrong flag or arming state shows at the ports in two ways: the status byte reads wrong, and `irq` is wrong in the very next cycle once the enable is high and the mask is low. A lock bit stuck set or left clear shows within one capture: a later read returns a stale or a torn value. A prescaler or synchroniser fault shifts captured values by whole counts, so the bench predicts each timestamp to the exact count and checks both the cycle in which the flag rises and the cycle before it. Overflow handling is checked at the exact wrap cycle.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CNT_W = 16;
  localparam int NCH   = 2;
  localparam int SEL_W = 2;

  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_CNT_HI = 3'd5;
  localparam logic [2:0] A_CNT_LO = 3'd6;

  // capture register of channel ch: high byte at 1+2ch, low byte at 2+2ch
  function automatic logic [2:0] hi_addr(input int ch);
    return 3'(1 + 2 * ch);
  endfunction
  function automatic logic [2:0] lo_addr(input int ch);
    return 3'(2 + 2 * ch);
  endfunction

  localparam int OVF_BIT = 2;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask_c;

  // ratio 2^sel: a tick whenever the low sel bits of the free divider are all ones
  assign mask_c = ~({DIV_W{1'b1}} << clk_sel);
  assign tick   = &(div_q | ~mask_c);

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign wrap = tick & (&cnt_q);

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/dct_capture_ch.sv
module dct_capture_ch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic         rising,
  input  logic         cap_en,
  input  logic [W-1:0] cnt,
  input  logic         hi_rd,
  input  logic         lo_acc,
  input  logic         stat_rd,
  output logic [W-1:0] cap_val,
  output logic         flag
);
  logic         s1_q, s2_q, prev_q;
  logic         edge_c, accept_c;
  logic [W-1:0] cap_q;
  logic         flag_q, arm_q, frozen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign edge_c   = rising ? (s2_q & ~prev_q) : (~s2_q & prev_q);
  assign accept_c = edge_c & cap_en & ~frozen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (accept_c) begin
      cap_q  <= cnt;
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else begin
      if (stat_rd && flag_q) arm_q <= 1'b1;
      if (lo_acc && arm_q) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      frozen_q <= 1'b0;
    else if (lo_acc) frozen_q <= 1'b0;
    else if (hi_rd)  frozen_q <= 1'b1;
  end

  assign cap_val = cap_q;
  assign flag    = flag_q;

  // R3
  capture_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_c |=> (flag_q && cap_q == $past(cnt)));

  // R6
  clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q) |=> flag_q);

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> ($stable(cap_q) && !$rose(flag_q)));
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [NCH-1:0]   edge_sel,
  input  logic             cap_irq_en,
  input  logic             irq_mask,
  input  logic             wave_mode,
  input  logic [NCH-1:0]   cap_pin,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  output logic [7:0]       bus_rdata,
  output logic             irq
);
  localparam int KEEP_CH = 1;

  logic             tick, wrap;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cap_val [NCH];
  logic [NCH-1:0]   flags;
  logic             stat_rd, bus_acc;
  logic             ovf_q, ovf_arm_q;

  assign stat_rd = bus_rd && (bus_addr == A_STATUS);
  assign bus_acc = bus_rd || bus_wr;

  dct_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick)
  );

  dct_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .wrap(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic en_c;
    if (i == KEEP_CH) begin : g_keep
      assign en_c = 1'b1;
    end else begin : g_wave
      assign en_c = ~wave_mode;
    end

    dct_capture_ch #(.W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (cap_pin[i]),
      .rising  (edge_sel[i]),
      .cap_en  (en_c),
      .cnt     (cnt),
      .hi_rd   (bus_rd && (bus_addr == hi_addr(i))),
      .lo_acc  (bus_acc && (bus_addr == lo_addr(i))),
      .stat_rd (stat_rd),
      .cap_val (cap_val[i]),
      .flag    (flags[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q     <= 1'b0;
      ovf_arm_q <= 1'b0;
    end else if (wrap) begin
      ovf_q     <= 1'b1;
      ovf_arm_q <= 1'b0;
    end else begin
      if (stat_rd && ovf_q) ovf_arm_q <= 1'b1;
      if (bus_acc && bus_addr == A_CNT_LO && ovf_arm_q) begin
        ovf_q     <= 1'b0;
        ovf_arm_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      A_STATUS: begin
        bus_rdata[NCH-1:0] = flags;
        bus_rdata[OVF_BIT] = ovf_q;
      end
      A_CNT_HI: bus_rdata = cnt[15:8];
      A_CNT_LO: bus_rdata = cnt[7:0];
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (bus_addr == hi_addr(i)) bus_rdata = cap_val[i][15:8];
          if (bus_addr == lo_addr(i)) bus_rdata = cap_val[i][7:0];
        end
      end
    endcase
  end

  assign irq = (|flags) & cap_irq_en & ~irq_mask;

  // R11
  wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_q);

  // R10
  wave_blocks_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_mode |=> $stable(cap_val[0]));

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));
endmodule

// File: tb/dual_capture_timer_bench.sv
module dual_capture_timer_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] clk_sel, edge_sel, cap_pin;
  logic       cap_irq_en, irq_mask, wave_mode;
  logic       bus_rd, bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mcnt;

  always #(CLK_P/2) clk = ~clk;

  dual_capture_timer u_dual_capture_timer (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .edge_sel(edge_sel),
    .cap_irq_en(cap_irq_en), .irq_mask(irq_mask), .wave_mode(wave_mode),
    .cap_pin(cap_pin), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // counter model for divide ratio 1 (R2): one count per clock since reset release
  always_ff @(posedge clk) begin
    if (!rst_n) mcnt <= '0;
    else        mcnt <= mcnt + 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_rd = 1'b1;
    #1 d = bus_rdata;
    cyc(1);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a);
    bus_addr = a;
    bus_wr = 1'b1;
    cyc(1);
    bus_wr = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rst_n = 1'b0;
    clk_sel = sel; edge_sel = 2'b01; cap_pin = 2'b00;
    cap_irq_en = 1'b0; irq_mask = 1'b0; wave_mode = 1'b0;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  // drive pin i at a falling clock edge; returns the timestamp R3 predicts
  task automatic drive_pin(input int i, input logic v, output logic [15:0] exp_ts);
    cap_pin[i] = v;
    exp_ts = mcnt + 16'd2;
  endtask

  task automatic read_cap(input int ch, output logic [15:0] val);
    logic [7:0] h, l;
    rd(3'(1 + 2 * ch), h);
    rd(3'(2 + 2 * ch), l);
    val = {h, l};
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset(2'd0);
    peek(3'd0, d); check(d == 8'h00, "R1 status", d, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    for (int a = 1; a <= 4; a++) begin
      peek(3'(a), d); check(d == 8'h00, "R1 capture byte", d, 0);
    end
  endtask

  task automatic t_capture();
    logic [7:0] d;
    logic [15:0] e0, e1, v;
    do_reset(2'd0);
    edge_sel = 2'b01;
    cyc(2);
    drive_pin(0, 1'b1, e0);
    cyc(2);
    peek(3'd0, d); check(d[0] == 1'b0, "R3 flag not yet at k+1", d[0], 0);
    cyc(1);
    peek(3'd0, d); check(d == 8'h01, "R3 R5 flag at k+2", d, 8'h01);
    read_cap(0, v); check(v == e0, "R3 channel 0 timestamp", v, e0);
    // R4: channel 1 falling; its rising transition must not capture
    cap_pin[1] = 1'b1;
    cyc(5);
    peek(3'd0, d); check(d[1] == 1'b0, "R4 rising ignored on falling channel", d[1], 0);
    drive_pin(1, 1'b0, e1);
    cyc(3);
    peek(3'd0, d); check(d[1] == 1'b1, "R4 R5 channel 1 flag", d[1], 1);
    read_cap(1, v); check(v == e1, "R4 channel 1 timestamp", v, e1);
    // R4: falling transition on rising channel 0 ignored
    cap_pin[0] = 1'b0;
    cyc(5);
    read_cap(0, v); check(v == e0, "R4 falling ignored on rising channel", v, e0);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    logic [15:0] e;
    // flags 0 and 1 are set from t_capture
    rd(3'd2, d);
    peek(3'd0, d); check(d[0] == 1'b1, "R6 unarmed low access keeps flag", d[0], 1);
    rd(3'd0, d);
    wr(3'd2);
    peek(3'd0, d); check(d[0] == 1'b0, "R6 status read then low write clears", d[0], 0);
    rd(3'd0, d);
    rd(3'd4, d);
    peek(3'd0, d); check(d[1] == 1'b0, "R6 status read then low read clears", d[1], 0);
    // R7: capture between the two steps cancels arming
    drive_pin(0, 1'b1, e); cyc(4);
    rd(3'd0, d);
    cap_pin[0] = 1'b0; cyc(4);
    drive_pin(0, 1'b1, e); cyc(4);
    wr(3'd2);
    peek(3'd0, d); check(d[0] == 1'b1, "R7 new capture cancels arming", d[0], 1);
    rd(3'd0, d);
    wr(3'd2);
    peek(3'd0, d); check(d[0] == 1'b0, "R7 re-armed clear", d[0], 0);
  endtask

  task automatic t_freeze();
    logic [7:0] d, h, l;
    logic [15:0] old, e, v;
    peek(3'd1, h); peek(3'd2, l); old = {h, l};
    cap_pin[0] = 1'b0; cyc(4);
    rd(3'd1, d);
    drive_pin(0, 1'b1, e); cyc(5);
    peek(3'd0, d); check(d[0] == 1'b0, "R8 locked channel sets no flag", d[0], 0);
    rd(3'd2, l);
    check({h, l} == old, "R8 locked register unchanged", {h, l}, old);
    cap_pin[0] = 1'b0; cyc(4);
    drive_pin(0, 1'b1, e); cyc(4);
    read_cap(0, v); check(v == e, "R8 unlocked after low read", v, e);
    rd(3'd0, d); rd(3'd2, d);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    logic [15:0] e;
    cap_irq_en = 1'b0; irq_mask = 1'b0;
    cap_pin[1] = 1'b1; cyc(4);
    drive_pin(1, 1'b0, e); cyc(4);
    check(irq == 1'b0, "R9 disabled", irq, 0);
    cap_irq_en = 1'b1; irq_mask = 1'b1; #1;
    check(irq == 1'b0, "R9 masked", irq, 0);
    irq_mask = 1'b0; #1;
    check(irq == 1'b1, "R9 pending raises", irq, 1);
    rd(3'd0, d); rd(3'd4, d); #1;
    check(irq == 1'b0, "R9 drops after clear", irq, 0);
    cap_irq_en = 1'b0;
  endtask

  task automatic t_wave();
    logic [7:0] d, h, l;
    logic [15:0] old, e;
    peek(3'd1, h); peek(3'd2, l); old = {h, l};
    wave_mode = 1'b1;
    cap_pin[0] = 1'b0; cap_pin[1] = 1'b1; cyc(4);
    drive_pin(0, 1'b1, e);
    cap_pin[1] = 1'b0; cyc(5);
    peek(3'd0, d); check(d[1:0] == 2'b10, "R10 only channel 1 captures", d[1:0], 2);
    peek(3'd1, h); peek(3'd2, l);
    check({h, l} == old, "R10 channel 0 register kept", {h, l}, old);
    wave_mode = 1'b0;
  endtask

  task automatic t_prescale();
    logic [7:0] d;
    do_reset(2'd3);
    cyc(79);
    peek(3'd6, d); check(d == 8'd9, "R2 ratio 8 before tick", d, 9);
    cyc(1);
    peek(3'd6, d); check(d == 8'd10, "R2 ratio 8", d, 10);
    do_reset(2'd1);
    cyc(20);
    peek(3'd6, d); check(d == 8'd10, "R2 ratio 2", d, 10);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    do_reset(2'd0);
    cyc(65535);
    peek(3'd5, d); check(d == 8'hFF, "R11 counter high at FFFF", d, 8'hFF);
    peek(3'd0, d); check(d[2] == 1'b0, "R11 no flag before wrap", d[2], 0);
    cyc(1);
    peek(3'd0, d); check(d == 8'h04, "R11 R5 flag at wrap", d, 8'h04);
    peek(3'd6, d); check(d == 8'h00, "R11 counter wrapped", d, 0);
    rd(3'd6, d);
    peek(3'd0, d); check(d[2] == 1'b1, "R11 unarmed access keeps flag", d[2], 1);
    rd(3'd0, d); wr(3'd6);
    peek(3'd0, d); check(d[2] == 1'b0, "R11 cleared", d[2], 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_capture();
    t_clear();
    t_freeze();
    t_irq();
    t_wave();
    t_prescale();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule